// File: doc/BRIEF.md
# Motor Speed Discriminator with Lock Supervisor

This block judges how far a motor's rotation speed is from a commanded speed and watches for a motor that never reaches that speed. The motor's speed feedback arrives as a pulse train on `fg`. The commanded speed arrives as a slow external clock on `ref_clk`. Both are already synchronous to `clk`. The block measures the spacing between rising edges of each input in `clk` cycles. The target feedback period is the external clock's period divided by 2^`DIV_LOG2`. The default divisor of 1024 matches an internal frequency multiplication of 1024.

At every new feedback edge the block produces a signed speed error for a downstream integrator. A positive value asks for more drive and a negative value asks for less. It also drives an active-low lock flag that is low while the speed lies within one sixteenth (6.25 %) of the target. A slow timer tick counts how long the motor stays outside that band. After `LP_COUNT` ticks (96 by default) a motor-lock fault is latched and the gate-off request is raised. The fault is released only when standby or short-brake is first asserted and then both are withdrawn. An undervoltage flag also forces gate-off, but it does not pause the lock timer.

Top module: `speed_disc_lock`

## Requirements
- R1: During and right after reset, `err` is 0, `lock_n` is 1 and `fault` is 0. `drive_off` then equals `uv`.
- R2: The target period is the spacing between the two most recent `ref_clk` rising edges in `clk` cycles, shifted right by `DIV_LOG2`. A target is known only once two edges have been seen.
- R3: The measured period is the spacing in `clk` cycles between the two most recent `fg` rising edges. At each `fg` rising edge after the first, once a target is known, `err` takes the value measured minus target as two's complement from the next cycle on. It then holds until the next such edge.
- R4: When measured minus target lies outside the signed range of `ERR_W` bits, `err` takes the nearest end of that range. For `ERR_W`=6 the range is +31 to -32.
- R5: `lock_n` is 0 when, at the latest evaluation, |measured − target| ≤ target >> 4. It is 1 otherwise. It is 1 until the first evaluation and changes only in the cycle after an `fg` rising edge.
- R6: With `stop` and `brake` low and no fault present, the block counts each `lp_tick` cycle in which the speed is out of band (the new verdict if an evaluation happens in that cycle, else `lock_n`). An in-band evaluation returns the count to zero. The tick that reaches `LP_COUNT` sets `fault` on the next cycle.
- R7: `fault` stays set regardless of `fg` and `lp_tick`. It clears in the cycle after the first sample where `stop` and `brake` are both low, provided one of them was seen high while the fault was set. While either is high, the out-of-band count is held at zero.
- R8: `uv` has no effect on the out-of-band count. `drive_off` is high whenever `fault` or `uv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fg | input | 1 | Motor speed feedback pulse level |
| ref_clk | input | 1 | Slow external speed command clock level |
| lp_tick | input | 1 | One-cycle lock timer tick |
| stop | input | 1 | Standby request, high = standby |
| brake | input | 1 | Short-brake request, high = brake |
| uv | input | 1 | Undervoltage protection active |
| err | output | ERR_W | Signed speed error, positive = accelerate |
| lock_n | output | 1 | Active-low speed-in-band indicator |
| fault | output | 1 | Latched motor-lock fault |
| drive_off | output | 1 | Request to switch all gates off |

## Verification
The feedback period is swept across the band edges. Periods of target+3 and target+4, and of target−3 and target−4, separate an inclusive window from an exclusive one on both sides. Periods of twice and one fifth of the target drive the error into both saturation limits, and retuning the reference clock shows that the target follows `ref_clk` and not a constant. The lock timer is run out of band, interrupted by an in-band stretch, and then run to expiry. This distinguishes a counter that restarts from one that only pauses. The fault is then cleared once through `brake` and once through `stop`, with a second expiry made under undervoltage.

// File: rtl/speed_disc_lock.sv
module speed_disc_lock #(
  parameter int CNT_W    = 24,
  parameter int ERR_W    = 16,
  parameter int DIV_LOG2 = 10,
  parameter int WIN_LOG2 = 4,
  parameter int LP_COUNT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fg,
  input  logic             ref_clk,
  input  logic             lp_tick,
  input  logic             stop,
  input  logic             brake,
  input  logic             uv,
  output logic [ERR_W-1:0] err,
  output logic             lock_n,
  output logic             fault,
  output logic             drive_off
);

  localparam int LP_W = $clog2(LP_COUNT);
  localparam logic signed [CNT_W:0] E_HI = (CNT_W+1)'(2**(ERR_W-1) - 1);
  localparam logic signed [CNT_W:0] E_LO = ~E_HI;

  logic             fg_d, ck_d, fg_seen, ck_seen, ref_ok, armed;
  logic [CNT_W-1:0] fg_cnt, ck_cnt, ref_q;
  logic [LP_W-1:0]  lp_cnt;

  wire fg_rise = fg & ~fg_d;
  wire ck_rise = ref_clk & ~ck_d;
  wire eval    = fg_rise & fg_seen & ref_ok;

  logic signed [CNT_W:0] diff;
  logic        [CNT_W:0] mag;
  logic                  in_win, out_now;
  logic [ERR_W-1:0]      err_next;

  assign diff     = $signed({1'b0, fg_cnt}) - $signed({1'b0, ref_q});
  assign mag      = diff[CNT_W] ? -diff : diff;
  assign in_win   = mag <= {1'b0, ref_q >> WIN_LOG2};
  assign out_now  = eval ? ~in_win : lock_n;
  assign err_next = (diff > E_HI) ? E_HI[ERR_W-1:0] :
                    (diff < E_LO) ? E_LO[ERR_W-1:0] : diff[ERR_W-1:0];
  assign drive_off = fault | uv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_d    <= 1'b0;
      ck_d    <= 1'b0;
      fg_cnt  <= '0;
      ck_cnt  <= '0;
      fg_seen <= 1'b0;
      ck_seen <= 1'b0;
      ref_ok  <= 1'b0;
      ref_q   <= '0;
    end else begin
      fg_d   <= fg;
      ck_d   <= ref_clk;
      fg_cnt <= fg_rise ? CNT_W'(1) : fg_cnt + {{(CNT_W-1){1'b0}}, ~&fg_cnt};
      ck_cnt <= ck_rise ? CNT_W'(1) : ck_cnt + {{(CNT_W-1){1'b0}}, ~&ck_cnt};
      if (fg_rise) fg_seen <= 1'b1;
      if (ck_rise) begin
        ck_seen <= 1'b1;
        if (ck_seen) begin
          ref_q  <= ck_cnt >> DIV_LOG2;
          ref_ok <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= '0;
      lock_n <= 1'b1;
    end else if (eval) begin
      err    <= err_next;
      lock_n <= ~in_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_cnt <= '0;
      fault  <= 1'b0;
      armed  <= 1'b0;
    end else if (stop | brake) begin
      lp_cnt <= '0;
      if (fault) armed <= 1'b1;
    end else if (fault) begin
      if (armed) begin
        fault  <= 1'b0;
        armed  <= 1'b0;
        lp_cnt <= '0;
      end
    end else if (eval & in_win) begin
      lp_cnt <= '0;
    end else if (lp_tick & out_now) begin
      if (lp_cnt == LP_W'(LP_COUNT - 1)) begin
        fault  <= 1'b1;
        lp_cnt <= '0;
      end else begin
        lp_cnt <= lp_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/speed_disc_lock_chk.sv
module speed_disc_lock_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fg,
  input logic             lp_tick,
  input logic             stop,
  input logic             brake,
  input logic             uv,
  input logic [ERR_W-1:0] err,
  input logic             lock_n,
  input logic             fault,
  input logic             drive_off
);

  logic fg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fg_q <= 1'b0;
    else        fg_q <= fg;
  end

  a_r3_err_moves_on_fg: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err) |-> $past(fg && !fg_q));

  a_r5_lock_moves_on_fg: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_n) |-> $past(fg && !fg_q));

  a_r6_fault_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(lp_tick));

  a_r7_hold_while_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (stop || brake)) |=> fault);

  a_r7_clear_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> (!$past(stop) && !$past(brake)));

  a_r8_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    (uv || fault) |-> drive_off);

endmodule

bind speed_disc_lock speed_disc_lock_chk #(.ERR_W(ERR_W)) chk_i (.*);

// File: tb/speed_disc_lock_tb_top.sv
module speed_disc_lock_tb_top;

  localparam int DIV = 4;
  localparam int EW  = 6;
  localparam int LPC = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fg = 1'b0, ref_clk = 1'b0, lp_tick = 1'b0;
  logic stop = 1'b1, brake = 1'b0, uv = 1'b0;
  logic [EW-1:0] err;
  logic lock_n, fault, drive_off;

  always #10 clk = ~clk;

  speed_disc_lock #(.CNT_W(16), .ERR_W(EW), .DIV_LOG2(DIV), .LP_COUNT(LPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fg(fg), .ref_clk(ref_clk), .lp_tick(lp_tick),
    .stop(stop), .brake(brake), .uv(uv), .err(err), .lock_n(lock_n),
    .fault(fault), .drive_off(drive_off));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int fg_per = 50, ck_per = 800;
  bit tick_en = 0;
  int fcnt = 0, ccnt = 0, tcnt = 0;

  always @(negedge clk) begin
    fcnt = fcnt + 1;
    if (fcnt >= fg_per) begin fg = 1'b1; fcnt = 0; end else fg = 1'b0;
    ccnt = ccnt + 1;
    if (ccnt >= ck_per) begin ref_clk = 1'b1; ccnt = 0; end else ref_clk = 1'b0;
    tcnt = tcnt + 1;
    if (tick_en && tcnt >= 4) begin lp_tick = 1'b1; tcnt = 0; end else lp_tick = 1'b0;
  end

  // behavioural reference: edge times instead of running counters
  int cyc, last_fg, last_ck, m_ref, m_err, m_cnt;
  bit m_fgp, m_ckp, m_fgseen, m_ckseen, m_refok, m_lock_n, m_fault, m_armed;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_fg = 0; last_ck = 0; m_ref = 0; m_err = 0; m_cnt = 0;
      m_fgp = 0; m_ckp = 0; m_fgseen = 0; m_ckseen = 0; m_refok = 0;
      m_lock_n = 1; m_fault = 0; m_armed = 0;
    end else begin
      bit fr, cr, ev, inw, old_lock;
      int d;
      cyc = cyc + 1;
      fr = fg && !m_fgp;
      cr = ref_clk && !m_ckp;
      m_fgp = fg;
      m_ckp = ref_clk;
      ev = fr && m_fgseen && m_refok;
      inw = 0;
      old_lock = m_lock_n;
      if (ev) begin
        d = (cyc - last_fg) - m_ref;
        m_err = (d > 31) ? 31 : (d < -32) ? -32 : d;
        inw = ((d < 0) ? -d : d) <= (m_ref / 16);
        m_lock_n = !inw;
      end
      if (fr) begin last_fg = cyc; m_fgseen = 1; end
      if (cr) begin
        if (m_ckseen) begin m_ref = (cyc - last_ck) / (1 << DIV); m_refok = 1; end
        last_ck = cyc;
        m_ckseen = 1;
      end
      if (stop || brake) begin
        m_cnt = 0;
        if (m_fault) m_armed = 1;
      end else if (m_fault) begin
        if (m_armed) begin m_fault = 0; m_armed = 0; m_cnt = 0; end
      end else if (ev && inw) begin
        m_cnt = 0;
      end else if (lp_tick && (ev ? !inw : old_lock)) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == LPC) begin m_fault = 1; m_cnt = 0; end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R4 model err", int'($signed(err)), m_err);
      chk("R5 model lock_n", int'(lock_n), int'(m_lock_n));
      chk("R6/R7 model fault", int'(fault), int'(m_fault));
      chk("R8 model drive_off", int'(drive_off), int'(m_fault || uv));
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fg(int p);
    fg_per = p;
    wait_cyc(3 * p + 5);
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 reset err", int'($signed(err)), 0);
    chk("R1 reset lock_n", int'(lock_n), 1);
    chk("R1 reset fault", int'(fault), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 after reset lock_n", int'(lock_n), 1);
    chk("R1 after reset drive_off", int'(drive_off), 0);

    wait_cyc(2200);
    chk("R3 on target err", int'($signed(err)), 0);
    chk("R5 on target lock_n", int'(lock_n), 0);

    set_fg(53);
    chk("R3 slow edge err", int'($signed(err)), 3);
    chk("R5 upper edge in band", int'(lock_n), 0);
    set_fg(54);
    chk("R3 slow err", int'($signed(err)), 4);
    chk("R5 above band", int'(lock_n), 1);
    set_fg(47);
    chk("R3 fast edge err", int'($signed(err)), -3);
    chk("R5 lower edge in band", int'(lock_n), 0);
    set_fg(46);
    chk("R3 fast err", int'($signed(err)), -4);
    chk("R5 below band", int'(lock_n), 1);
    set_fg(100);
    chk("R4 positive saturation", int'($signed(err)), 31);
    set_fg(10);
    chk("R4 negative saturation", int'($signed(err)), -32);

    fg_per = 50;
    ck_per = 640;
    wait_cyc(2500);
    chk("R2 retuned target err", int'($signed(err)), 10);
    chk("R2 retuned target lock_n", int'(lock_n), 1);
    ck_per = 800;
    wait_cyc(2500);
    chk("R2 restored target err", int'($signed(err)), 0);

    set_fg(100);
    tick_en = 1;
    stop = 1'b0;
    wait_cyc(300);
    chk("R6 before expiry", int'(fault), 0);
    fg_per = 50;
    wait_cyc(300);
    chk("R6 in band lock_n", int'(lock_n), 0);
    fg_per = 100;
    wait_cyc(320);
    chk("R6 count restarted", int'(fault), 0);
    wait_cyc(500);
    chk("R6 expiry fault", int'(fault), 1);
    chk("R6 expiry drive_off", int'(drive_off), 1);

    fg_per = 50;
    wait_cyc(400);
    chk("R7 fault held in band", int'(fault), 1);
    brake = 1'b1;
    wait_cyc(20);
    chk("R7 fault held during brake", int'(fault), 1);
    brake = 1'b0;
    wait_cyc(1);
    chk("R7 cleared by brake release", int'(fault), 0);
    wait_cyc(600);
    chk("R7 stays clear in band", int'(fault), 0);

    uv = 1'b1;
    wait_cyc(1);
    chk("R8 uv drive_off", int'(drive_off), 1);
    chk("R8 uv no fault", int'(fault), 0);
    fg_per = 100;
    wait_cyc(700);
    chk("R8 count runs under uv", int'(fault), 1);
    uv = 1'b0;
    wait_cyc(1);
    chk("R8 fault keeps drive_off", int'(drive_off), 1);
    stop = 1'b1;
    wait_cyc(10);
    chk("R7 fault held during stop", int'(fault), 1);
    stop = 1'b0;
    wait_cyc(1);
    chk("R7 cleared by stop release", int'(fault), 0);
    chk("R8 drive_off released", int'(drive_off), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule